// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two 16-bit ports, A and B, and is split into two byte-wide lanes that each have their own controls. Every lane holds two capture registers. One stores the lane's A input and can be replayed toward B. The other stores the lane's B input and can be replayed toward A. For each direction, a select input chooses whether the driven port carries the live data arriving from the opposite port or the stored register value. An active-low output enable and a direction input together decide which port of the lane, if either, is driven.

Each port is modelled as separate input, output and per-lane output-enable signals, so no tristate net is needed. The two capture registers are loaded through capture strobes sampled on the single block clock. Loading never depends on the output controls, so a lane can keep storing data while both of its ports are isolated. Tie the two lanes' controls together and the block acts as one 16-bit transceiver. Keep them separate and it acts as two independent byte transceivers.

Top module: `registered_bus_xcvr`

## Requirements
- R1: After a synchronous active-low reset, both capture registers of every lane hold zero.
- R2: When a lane's `cap_ab` bit is 1 at a rising clock edge, that lane's A-to-B register loads the lane's bits of `a_in`. Otherwise it keeps its value.
- R3: When a lane's `cap_ba` bit is 1 at a rising clock edge, that lane's B-to-A register loads the lane's bits of `b_in`. Otherwise it keeps its value.
- R4: For lane l, `b_oe[l]` = (`oe_n[l]`==0 and `dir[l]`==1) and `a_oe[l]` = (`oe_n[l]`==0 and `dir[l]`==0). The two enables of a lane are never 1 together.
- R5: While `b_oe[l]` is 1, the lane's bits of `b_out` equal the lane's `a_in` bits in the same cycle when `sel_ab[l]`=0. When `sel_ab[l]`=1 they equal the A-to-B register.
- R6: While `a_oe[l]` is 1, the lane's bits of `a_out` equal the lane's `b_in` bits in the same cycle when `sel_ba[l]`=0. When `sel_ba[l]`=1 they equal the B-to-A register.
- R7: A lane port whose enable is 0 drives zero on its data-out bits.
- R8: With `oe_n[l]`=1 (isolation), both registers of the lane still load on their strobes. Values stored before or during isolation are presented unchanged once the lane is enabled again.
- R9: Lane 0 occupies bits 7:0 and lane 1 occupies bits 15:8. A lane's controls affect only its own bits.
- R10: Loading a register is independent of `oe_n`, `dir`, `sel_ab` and `sel_ba`. Both registers can load in the same cycle while either port is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; registers load on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 16 | Data arriving on port A |
| b_in | input | 16 | Data arriving on port B |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab | input | 2 | Per-lane B source: 0 live A, 1 stored A-to-B |
| sel_ba | input | 2 | Per-lane A source: 0 live B, 1 stored B-to-A |
| cap_ab | input | 2 | Per-lane strobe to load A data into the A-to-B register |
| cap_ba | input | 2 | Per-lane strobe to load B data into the B-to-A register |
| a_out | output | 16 | Data driven onto port A |
| a_oe | output | 2 | Per-lane enable for port A |
| b_out | output | 16 | Data driven onto port B |
| b_oe | output | 2 | Per-lane enable for port B |

## Verification
A wrong stored value stays hidden until that lane is enabled toward the register's destination with the stored-data select set. At that point the error shows on the data outputs in the same cycle, with no further delay. A missed or extra load shows one clock after the strobe edge, in the first cycle that selects the register. Enable or select decode faults are purely combinational and appear at once on `a_oe`, `b_oe` or the data outputs. For that reason the bench sweeps every control combination per lane against a model of the stored values that the bench keeps itself.

// File: rtl/registered_bus_pkg.sv
// Package: shared sizing for the registered bus transceiver.
// Assumes lanes are equal width and laid out from bit 0 upward.
package registered_bus_pkg;
    parameter int unsigned XCVR_LANES  = 2;
    parameter int unsigned XCVR_LANE_W = 8;
    localparam int unsigned XCVR_BUS_W = XCVR_LANES * XCVR_LANE_W;
endpackage

// File: rtl/xcvr_store_reg.sv
// Module: one capture register of a lane.
// Loads d on a rising clk edge when cap is 1, holds otherwise.
// Assumes a synchronous active-low reset that clears the contents.
module xcvr_store_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: clear on reset, load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap) begin
            q <= d;
        end
    end
endmodule

// File: rtl/xcvr_sel_mux.sv
// Module: hazard-free live/stored selector with output gating.
// The consensus term (live & stored) keeps a bit steady while sel
// switches, provided both data inputs agree on that bit.
// The output is zero whenever en is 0.
module xcvr_sel_mux #(
    parameter int unsigned W = 8
) (
    input  logic         sel,
    input  logic         en,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);
    logic [W-1:0] sel_v;
    logic [W-1:0] pick;

    // Purpose: sum-of-products select with a consensus term, then gate.
    always_comb begin
        sel_v = {W{sel}};
        pick  = (live & ~sel_v) | (stored & sel_v) | (live & stored);
        y     = pick & {W{en}};
    end
endmodule

// File: rtl/xcvr_lane.sv
// Module: one lane of the transceiver.
// Holds two capture registers and two selectors, and decodes the
// lane's port enables from oe_n and dir.
// Assumes loading never depends on the output controls.
module xcvr_lane #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         cap_ab,
    input  logic         cap_ba,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [W-1:0] hold_ab;
    logic [W-1:0] hold_ba;

    // Purpose: decode which port this lane drives (at most one).
    always_comb begin
        b_oe = ~oe_n & dir;
        a_oe = ~oe_n & ~dir;
    end

    xcvr_store_reg #(.W(W)) u_reg_ab (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (cap_ab),
        .d    (a_in),
        .q    (hold_ab)
    );

    xcvr_store_reg #(.W(W)) u_reg_ba (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (cap_ba),
        .d    (b_in),
        .q    (hold_ba)
    );

    xcvr_sel_mux #(.W(W)) u_mux_b (
        .sel   (sel_ab),
        .en    (b_oe),
        .live  (a_in),
        .stored(hold_ab),
        .y     (b_out)
    );

    xcvr_sel_mux #(.W(W)) u_mux_a (
        .sel   (sel_ba),
        .en    (a_oe),
        .live  (b_in),
        .stored(hold_ba),
        .y     (a_out)
    );
endmodule

// File: rtl/registered_bus_xcvr.sv
// Module: top of the registered bidirectional bus transceiver.
// Instantiates one lane per group of LANE_W bits, lane 0 at the
// bottom. Ports are split into in/out/enable; there is no tristate net.
module registered_bus_xcvr
    import registered_bus_pkg::*;
#(
    parameter int unsigned NUM_LANES = XCVR_LANES,
    parameter int unsigned LANE_W    = XCVR_LANE_W,
    localparam int unsigned BUS_W    = NUM_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_W-1:0]     a_in,
    input  logic [BUS_W-1:0]     b_in,
    input  logic [NUM_LANES-1:0] oe_n,
    input  logic [NUM_LANES-1:0] dir,
    input  logic [NUM_LANES-1:0] sel_ab,
    input  logic [NUM_LANES-1:0] sel_ba,
    input  logic [NUM_LANES-1:0] cap_ab,
    input  logic [NUM_LANES-1:0] cap_ba,
    output logic [BUS_W-1:0]     a_out,
    output logic [NUM_LANES-1:0] a_oe,
    output logic [BUS_W-1:0]     b_out,
    output logic [NUM_LANES-1:0] b_oe
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        xcvr_lane #(.W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .a_in  (a_in[g*LANE_W +: LANE_W]),
            .b_in  (b_in[g*LANE_W +: LANE_W]),
            .oe_n  (oe_n[g]),
            .dir   (dir[g]),
            .sel_ab(sel_ab[g]),
            .sel_ba(sel_ba[g]),
            .cap_ab(cap_ab[g]),
            .cap_ba(cap_ba[g]),
            .a_out (a_out[g*LANE_W +: LANE_W]),
            .a_oe  (a_oe[g]),
            .b_out (b_out[g*LANE_W +: LANE_W]),
            .b_oe  (b_oe[g])
        );
    end
endmodule

// File: rtl/xcvr_checker.sv
// Module: port-level property checker, bound to registered_bus_xcvr.
// Checks enable exclusivity, gating, live paths and register load/hold
// as they appear at the ports.
module xcvr_checker #(
    parameter int unsigned NUM_LANES = 2,
    parameter int unsigned LANE_W    = 8,
    localparam int unsigned BUS_W    = NUM_LANES * LANE_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [BUS_W-1:0]     a_in,
    input logic [BUS_W-1:0]     b_in,
    input logic [NUM_LANES-1:0] oe_n,
    input logic [NUM_LANES-1:0] dir,
    input logic [NUM_LANES-1:0] sel_ab,
    input logic [NUM_LANES-1:0] sel_ba,
    input logic [NUM_LANES-1:0] cap_ab,
    input logic [NUM_LANES-1:0] cap_ba,
    input logic [BUS_W-1:0]     a_out,
    input logic [NUM_LANES-1:0] a_oe,
    input logic [BUS_W-1:0]     b_out,
    input logic [NUM_LANES-1:0] b_oe
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
        // R4
        en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_oe[g] && b_oe[g]));
        // R4
        en_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n[g] |-> (!a_oe[g] && !b_oe[g]));
        // R7
        b_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !b_oe[g] |-> (b_out[g*LANE_W +: LANE_W] == '0));
        // R7
        a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !a_oe[g] |-> (a_out[g*LANE_W +: LANE_W] == '0));
        // R5
        b_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (b_oe[g] && !sel_ab[g]) |->
                (b_out[g*LANE_W +: LANE_W] == a_in[g*LANE_W +: LANE_W]));
        // R6
        a_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_oe[g] && !sel_ba[g]) |->
                (a_out[g*LANE_W +: LANE_W] == b_in[g*LANE_W +: LANE_W]));
        // R2
        ab_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cap_ab[g]) && b_oe[g] && sel_ab[g]) |->
                (b_out[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W])));
        // R3
        ba_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cap_ba[g]) && a_oe[g] && sel_ba[g]) |->
                (a_out[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W])));
        // R8
        ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(cap_ab[g]) && $past(b_oe[g] && sel_ab[g])
                && b_oe[g] && sel_ab[g]) |-> $stable(b_out[g*LANE_W +: LANE_W]));
    end
endmodule

bind registered_bus_xcvr xcvr_checker #(
    .NUM_LANES(NUM_LANES),
    .LANE_W   (LANE_W)
) u_xcvr_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a_in  (a_in),
    .b_in  (b_in),
    .oe_n  (oe_n),
    .dir   (dir),
    .sel_ab(sel_ab),
    .sel_ba(sel_ba),
    .cap_ab(cap_ab),
    .cap_ba(cap_ba),
    .a_out (a_out),
    .a_oe  (a_oe),
    .b_out (b_out),
    .b_oe  (b_oe)
);

// File: tb/tb_registered_bus_xcvr.sv
// Directed bench: the bench keeps its own model of the stored bytes and
// compares every port against it after each stimulus.
module tb_registered_bus_xcvr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [1:0]  oe_n = 2'b11, dir = '0, sel_ab = '0, sel_ba = '0;
    logic [1:0]  cap_ab = '0, cap_ba = '0;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_ab [2];
    logic [7:0] m_ba [2];

    always #4 clk = ~clk;

    registered_bus_xcvr dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic cmp(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare all outputs with the bench model (called mid-low-phase).
    task automatic check_all(string req);
        logic [15:0] eb, ea;
        logic [1:0]  xb, xa;
        for (int l = 0; l < 2; l++) begin
            xb[l] = !oe_n[l] && dir[l];
            xa[l] = !oe_n[l] && !dir[l];
            eb[l*8 +: 8] = !xb[l] ? 8'h00 : (sel_ab[l] ? m_ab[l] : a_in[l*8 +: 8]);
            ea[l*8 +: 8] = !xa[l] ? 8'h00 : (sel_ba[l] ? m_ba[l] : b_in[l*8 +: 8]);
        end
        cmp(req, "b_oe", {14'd0, b_oe}, {14'd0, xb});
        cmp(req, "a_oe", {14'd0, a_oe}, {14'd0, xa});
        cmp(req, "b_out", b_out, eb);
        cmp(req, "a_out", a_out, ea);
    endtask

    // One clock: update model at the edge, return at the falling edge.
    task automatic tick();
        @(posedge clk);
        for (int l = 0; l < 2; l++) begin
            if (!rst_n) begin
                m_ab[l] = '0; m_ba[l] = '0;
            end else begin
                if (cap_ab[l]) m_ab[l] = a_in[l*8 +: 8];
                if (cap_ba[l]) m_ba[l] = b_in[l*8 +: 8];
            end
        end
        @(negedge clk);
        cap_ab = '0; cap_ba = '0;
        #1;
    endtask

    task automatic t_reset();
        m_ab[0] = 8'h5A; m_ab[1] = 8'h5A; m_ba[0] = 8'h5A; m_ba[1] = 8'h5A;
        rst_n = 1'b0; cap_ab = 2'b11; cap_ba = 2'b11;
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        tick(); tick();
        rst_n = 1'b1;
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11; #1;
        check_all("R1");
        dir = 2'b00; sel_ba = 2'b11; #1;
        check_all("R1");
    endtask

    // Every oe_n/dir/sel_ab/sel_ba combination on one lane, other lane fixed.
    task automatic t_sweep(int lane);
        for (int c = 0; c < 16; c++) begin
            oe_n[lane] = c[0]; dir[lane] = c[1];
            sel_ab[lane] = c[2]; sel_ba[lane] = c[3];
            oe_n[1-lane] = 1'b0; dir[1-lane] = ~c[1];
            a_in = 16'h3C00 ^ 16'(c * 16'h1111); b_in = ~a_in; #1;
            check_all("R4");
            check_all("R9");
        end
    endtask

    task automatic t_live();
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b00;
        foreach (a_in[i]) begin
            a_in = 16'h1 << i; b_in = 16'hA5A5; #1;
            check_all("R5");
        end
        dir = 2'b00; sel_ba = 2'b00;
        for (int p = 0; p < 4; p++) begin
            b_in = 16'hF0F0 >> p; a_in = 16'h0F0F; #1;
            check_all("R6");
            check_all("R7");
        end
    endtask

    task automatic t_store();
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b00;
        a_in = 16'hBEEF; cap_ab = 2'b11; tick();
        a_in = 16'h1234; sel_ab = 2'b11; #1;
        check_all("R2");
        tick();
        check_all("R2");
        dir = 2'b00; sel_ba = 2'b00;
        b_in = 16'hC0DE; cap_ba = 2'b01; tick();
        b_in = 16'h7777; sel_ba = 2'b11; #1;
        check_all("R3");
    endtask

    task automatic t_isolate();
        oe_n = 2'b11; a_in = 16'h9A8B; b_in = 16'h6C5D;
        cap_ab = 2'b11; cap_ba = 2'b11; tick();
        check_all("R8");
        a_in = 16'h0000; b_in = 16'hFFFF;
        tick(); tick();
        oe_n = 2'b00; dir = 2'b10; sel_ab = 2'b11; sel_ba = 2'b11; #1;
        check_all("R8");
        dir = 2'b01; #1;
        check_all("R8");
    endtask

    task automatic t_capture_indep();
        for (int c = 0; c < 16; c++) begin
            oe_n = {c[0], c[1]}; dir = {c[2], c[1]}; sel_ab = {c[3], c[0]}; sel_ba = {c[1], c[3]};
            a_in = 16'(c * 16'h0F13 + 16'h2468); b_in = 16'(c * 16'h1357 + 16'h8ACE);
            cap_ab = c[1:0]; cap_ba = c[2:1]; tick();
            oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11; #1;
            check_all("R10");
            dir = 2'b00; sel_ba = 2'b11; #1;
            check_all("R10");
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); #1;
        t_reset();
        t_sweep(0);
        t_sweep(1);
        t_live();
        t_store();
        t_isolate();
        t_capture_indep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule